// File: doc/BRIEF.md
# Bayer White Balance Gain Stage

This block scales a raw single-plane Bayer pixel stream by one of four programmable gains, one pixel per clock. It follows the row and column parity of every pixel and uses a two-bit colour-filter phase to pick which of the four gains applies. Each sample is multiplied by its gain in unsigned 8.11 fixed point, rounded half-up and clamped to the sample width. Pixels enter and leave on ready/valid streams. Start-of-frame travels on `tuser` and end-of-line on `tlast`. The output stage holds its data under backpressure, so no pixel is lost.

Software programs the block through a small word-addressed register port. Gain and control writes go to shadow copies. A write to the commit register marks them pending, and they are copied into the active set when the next start-of-frame pixel is accepted. The settings in force therefore never change in the middle of a frame. The block also keeps an 8-bit checksum of each finished frame and a flag that shows whether a frame is in flight.

Top module: `wbg_top`

## Requirements
- R1: Offset 0x00 reads the constant 0x6FA7017A and offset 0x04 (colour plane count) reads 1.
- R2: With bypass clear, the output is min((sample × gain + 1024) >> 11, 2^DATA_W − 1). A gain of 0x00800 returns the sample unchanged.
- R3: The gain index for a pixel is {row_odd XOR phase[1], col_odd XOR phase[0]}. Here phase is CONTROL (offset 0x1C) bits 2:1, row and column count from 0 at the start-of-frame pixel, and GAINk sits at offset 0x20 + 4k.
- R4: When CONTROL bit 0 (bypass) is active, every output sample equals its input sample.
- R5: Writes to CONTROL and GAINk do not change processing until a write to COMMIT (offset 0x18) is made. The pending settings take effect from the next start-of-frame pixel onwards. STATUS (offset 0x10) bit 1 is 1 from the commit write until that pixel is accepted.
- R6: STATUS bit 0 is 1 from the acceptance of a start-of-frame pixel until the frame's last pixel (the `tlast` pixel of line HEIGHT−1) leaves the output.
- R7: CHECKSUM (offset 0x14) bits 7:0 hold the modulo-256 sum of the low bytes of all output samples of the most recently completed frame.
- R8: Under any `m_tready` pattern, the output sequence, including `tuser` and `tlast`, equals the input sequence processed in order. While `m_tvalid` is high and `m_tready` is low, the output holds.
- R9: WIDTH (0x08) and HEIGHT (0x0C) read back what was written. GAINk reads back bits 18:0 of the last write, with bits 31:19 at zero.
- R10: After reset, STATUS reads 0, CONTROL reads 0 and every GAINk reads 0x00800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | DATA_W | Input raw sample |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Block can accept an input sample |
| s_tuser | input | 1 | Input start-of-frame marker |
| s_tlast | input | 1 | Input end-of-line marker |
| m_tdata | output | DATA_W | Scaled output sample |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Downstream accepts the output sample |
| m_tuser | output | 1 | Output start-of-frame marker |
| m_tlast | output | 1 | Output end-of-line marker |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The hardest case to reach is a commit that is pending when a frame starts. The new gains must already apply to the start-of-frame pixel itself, yet the frame before it must have run entirely on the old settings. The bench rewrites all gains without committing and runs a full frame, checking that the old gains are still in force. It then commits, reads the pending flag, and sends the next frame, whose first pixel must already carry the new gain. The pixel-in-flight flag is read back between the first and later pixels of a frame. Separately, backpressure patterns stall the output while the input keeps offering data.

// File: rtl/wbg_pkg.sv
// Shared constants and types of the white balance gain stage.
// Assumes a word-addressed register port with byte offsets.
package wbg_pkg;
    localparam int GAIN_W = 19;
    localparam int FRAC_W = 11;
    localparam int NCH    = 4;
    localparam logic [31:0] ID_VALUE   = 32'h6FA7_017A;
    localparam logic [18:0] GAIN_UNITY = 19'h00800;

    localparam int OFS_ID     = 'h00;
    localparam int OFS_PLANES = 'h04;
    localparam int OFS_WIDTH  = 'h08;
    localparam int OFS_HEIGHT = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_CSUM   = 'h14;
    localparam int OFS_COMMIT = 'h18;
    localparam int OFS_CTRL   = 'h1C;
    localparam int OFS_GAIN0  = 'h20;

    typedef logic [GAIN_W-1:0] gain_t;

    // Bit layout matches the control register: [2:1] phase, [0] bypass.
    typedef struct packed {
        logic [1:0] phase;
        logic       bypass;
    } ctl_t;

    // Gain index of a pixel from its parity and the filter phase.
    function automatic logic [1:0] cfa_channel(input logic [1:0] phase,
                                               input logic row_odd,
                                               input logic col_odd);
        return {row_odd ^ phase[1], col_odd ^ phase[0]};
    endfunction
endpackage

// File: rtl/wbg_csr.sv
// Register file: shadow and active settings, commit handling, readback.
// Assumes reg_addr is a byte offset; reads are combinational.
module wbg_csr
    import wbg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 12,
    parameter int DEF_W  = 16,
    parameter int DEF_H  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              apply_req,
    input  logic              running,
    input  logic [7:0]        csum,
    output ctl_t              eff_ctl,
    output gain_t [NCH-1:0]   eff_gain,
    output logic [DIM_W-1:0]  height
);
    logic [DIM_W-1:0] width_q, height_q;
    ctl_t             shd_ctl, act_ctl;
    gain_t [NCH-1:0]  shd_gain, act_gain;
    logic             pending, apply, commit_hit;

    assign commit_hit = reg_we && (reg_addr == ADDR_W'(OFS_COMMIT));
    assign apply      = apply_req && pending;
    assign height     = height_q;
    assign eff_ctl    = apply ? shd_ctl : act_ctl;

    // Frame dimension registers, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= DIM_W'(DEF_W);
            height_q <= DIM_W'(DEF_H);
        end else if (reg_we && reg_addr == ADDR_W'(OFS_WIDTH)) begin
            width_q <= reg_wdata[DIM_W-1:0];
        end else if (reg_we && reg_addr == ADDR_W'(OFS_HEIGHT)) begin
            height_q <= reg_wdata[DIM_W-1:0];
        end
    end

    // Control shadow, active copy and pending-commit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_ctl <= '0;
            act_ctl <= '0;
            pending <= 1'b0;
        end else begin
            if (reg_we && reg_addr == ADDR_W'(OFS_CTRL)) shd_ctl <= ctl_t'(reg_wdata[2:0]);
            if (apply) act_ctl <= shd_ctl;
            if (commit_hit) pending <= 1'b1;
            else if (apply) pending <= 1'b0;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_gain
        // Per-channel gain shadow and active copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd_gain[k] <= GAIN_UNITY;
                act_gain[k] <= GAIN_UNITY;
            end else begin
                if (reg_we && reg_addr == ADDR_W'(OFS_GAIN0 + 4 * k))
                    shd_gain[k] <= reg_wdata[GAIN_W-1:0];
                if (apply) act_gain[k] <= shd_gain[k];
            end
        end
        assign eff_gain[k] = apply ? shd_gain[k] : act_gain[k];
    end

    // Readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_ID))     reg_rdata = ID_VALUE;
        if (reg_addr == ADDR_W'(OFS_PLANES)) reg_rdata = 32'd1;
        if (reg_addr == ADDR_W'(OFS_WIDTH))  reg_rdata = 32'(width_q);
        if (reg_addr == ADDR_W'(OFS_HEIGHT)) reg_rdata = 32'(height_q);
        if (reg_addr == ADDR_W'(OFS_STATUS)) reg_rdata = {30'd0, pending, running};
        if (reg_addr == ADDR_W'(OFS_CSUM))   reg_rdata = {24'd0, csum};
        if (reg_addr == ADDR_W'(OFS_CTRL))   reg_rdata = {29'd0, shd_ctl};
        for (int k = 0; k < NCH; k++)
            if (reg_addr == ADDR_W'(OFS_GAIN0 + 4 * k)) reg_rdata = 32'(shd_gain[k]);
    end

    // R5: a consumed commit leaves nothing pending.
    assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !commit_hit) |=> !pending);
    // R5: active settings move only when a commit is consumed.
    assert_active_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_ctl) && $stable(act_gain)));
    // R9: gain readback never shows bits above the gain field.
    assert_gain_hi_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(OFS_GAIN0) && reg_addr < ADDR_W'(OFS_GAIN0 + 4 * NCH))
        |-> (reg_rdata[31:GAIN_W] == '0));
endmodule

// File: rtl/wbg_pos.sv
// Position tracker: line count and column parity of the pixel at the input.
// Assumes tuser marks line 0 column 0 and tlast ends each line.
module wbg_pos #(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_fire,
    input  logic             s_tuser,
    input  logic             s_tlast,
    input  logic [DIM_W-1:0] height,
    output logic             row_odd,
    output logic             col_odd,
    output logic             eof
);
    logic [DIM_W-1:0] line_q, cur_line;
    logic             col_q, cur_col;

    assign cur_line = s_tuser ? '0 : line_q;
    assign cur_col  = s_tuser ? 1'b0 : col_q;
    assign row_odd  = cur_line[0];
    assign col_odd  = cur_col;
    assign eof      = s_tlast && (cur_line == height - DIM_W'(1));

    // Advance column parity per pixel and the line count per tlast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            col_q  <= 1'b0;
        end else if (s_fire) begin
            col_q  <= s_tlast ? 1'b0 : ~cur_col;
            line_q <= s_tlast ? cur_line + DIM_W'(1) : cur_line;
        end
    end

    // R3: the first pixel after end-of-line starts on an even column.
    assert_col_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fire && s_tlast) |=> !col_q);
endmodule

// File: rtl/wbg_scale.sv
// Gain datapath with one output register, frame flag and checksum.
// Assumes DATA_W >= 8; s_tready depends combinationally on m_tready.
module wbg_scale
    import wbg_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tuser,
    input  logic              s_tlast,
    input  logic              eof_in,
    input  logic              row_odd,
    input  logic              col_odd,
    input  ctl_t              ctl,
    input  gain_t [NCH-1:0]   gains,
    output logic              s_fire,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast,
    output logic              running,
    output logic [7:0]        csum
);
    localparam int PROD_W = DATA_W + GAIN_W;
    localparam int RND_W  = PROD_W + 1 - FRAC_W;
    localparam logic [PROD_W:0]  HALF    = (PROD_W + 1)'(1) << (FRAC_W - 1);
    localparam logic [RND_W-1:0] MAX_EXT = RND_W'({DATA_W{1'b1}});

    logic              m_eof, m_fire;
    logic [7:0]        acc, sum;
    gain_t             g;
    logic [PROD_W:0]   prod;
    logic [RND_W-1:0]  rnd;
    logic [DATA_W-1:0] scaled;

    assign s_tready = !m_tvalid || m_tready;
    assign s_fire   = s_tvalid && s_tready;
    assign m_fire   = m_tvalid && m_tready;

    // Select gain, multiply, round half-up and clamp.
    always_comb begin
        g      = gains[cfa_channel(ctl.phase, row_odd, col_odd)];
        prod   = (PROD_W + 1)'(s_tdata) * (PROD_W + 1)'(g);
        rnd    = RND_W'((prod + HALF) >> FRAC_W);
        scaled = (rnd > MAX_EXT) ? {DATA_W{1'b1}} : rnd[DATA_W-1:0];
    end

    // Output register, loaded when the downstream slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tuser  <= 1'b0;
            m_tlast  <= 1'b0;
            m_eof    <= 1'b0;
        end else if (s_tready) begin
            m_tvalid <= s_tvalid;
            if (s_tvalid) begin
                m_tdata <= ctl.bypass ? s_tdata : scaled;
                m_tuser <= s_tuser;
                m_tlast <= s_tlast;
                m_eof   <= eof_in;
            end
        end
    end

    assign sum = (m_tuser ? 8'd0 : acc) + m_tdata[7:0];

    // Checksum accumulation and frame-in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            csum    <= '0;
            running <= 1'b0;
        end else begin
            if (m_fire) begin
                acc <= m_eof ? 8'd0 : sum;
                if (m_eof) csum <= sum;
            end
            if (s_fire && s_tuser) running <= 1'b1;
            else if (m_fire && m_eof) running <= 1'b0;
        end
    end

    // R8: a stalled output holds still.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));
    // R4: bypass copies the accepted sample.
    assert_bypass_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fire && ctl.bypass) |=> (m_tdata == $past(s_tdata)));
    // R2: unity gain is exact.
    assert_unity_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fire && g == GAIN_UNITY) |=> (m_tdata == $past(s_tdata)));
    // R6: an accepted start-of-frame raises the frame flag.
    assert_running_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_fire && s_tuser) |=> running);
endmodule

// File: rtl/wbg_top.sv
// Top of the Bayer white balance gain stage: registers, tracker, datapath.
// Assumes one pixel per clock and a single colour plane.
module wbg_top
    import wbg_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 12,
    parameter int DEF_W  = 16,
    parameter int DEF_H  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tuser,
    input  logic              s_tlast,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    ctl_t             eff_ctl;
    gain_t [NCH-1:0]  eff_gain;
    logic [DIM_W-1:0] height;
    logic             s_fire, row_odd, col_odd, eof, running;
    logic [7:0]       csum;

    wbg_csr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .DEF_W(DEF_W), .DEF_H(DEF_H)) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .apply_req(s_fire && s_tuser), .running(running), .csum(csum),
        .eff_ctl(eff_ctl), .eff_gain(eff_gain), .height(height));

    wbg_pos #(.DIM_W(DIM_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .s_fire(s_fire), .s_tuser(s_tuser),
        .s_tlast(s_tlast), .height(height),
        .row_odd(row_odd), .col_odd(col_odd), .eof(eof));

    wbg_scale #(.DATA_W(DATA_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .eof_in(eof), .row_odd(row_odd), .col_odd(col_odd),
        .ctl(eff_ctl), .gains(eff_gain), .s_fire(s_fire),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast), .running(running), .csum(csum));
endmodule

// File: tb/test_wbg_top.sv
// Directed bench for wbg_top: one task per scenario, each checking itself.
module test_wbg_top;
    localparam int PERIOD = 10;
    localparam int DW     = 12;
    localparam int A_ID = 'h00, A_PL = 'h04, A_W = 'h08, A_H = 'h0C, A_ST = 'h10,
                   A_CS = 'h14, A_CM = 'h18, A_CT = 'h1C, A_G0 = 'h20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] s_tdata = '0, m_tdata;
    logic s_tvalid = 1'b0, s_tready, s_tuser = 1'b0, s_tlast = 1'b0;
    logic m_tvalid, m_tready = 1'b1, m_tuser, m_tlast;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int total = 0, bad = 0;
    int shd_g[4], act_g[4], shd_c = 0, act_c = 0;
    bit pend = 1'b0;
    int pix[256], expv[256];

    wbg_top i_wbg_top (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #(PERIOD / 2) clk = ~clk;

    initial begin
        #(PERIOD * 150000);
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        bad++; total++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 8'(a); reg_wdata = 32'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= A_G0 && a < A_G0 + 16) shd_g[(a - A_G0) / 4] = d & 'h7FFFF;
        if (a == A_CT) shd_c = d & 7;
        if (a == A_CM) pend = 1'b1;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 8'(a);
        #1 d = int'(reg_rdata);
    endtask

    function automatic int model(input int s, input int r, input int c);
        int ch, v;
        longint p;
        if (act_c[0]) return s;
        ch = ((r ^ ((act_c >> 2) & 1)) << 1) | (c ^ ((act_c >> 1) & 1));
        p = longint'(s) * longint'(act_g[ch]) + 1024;
        v = int'(p >> 11);
        return (v > 4095) ? 4095 : v;
    endfunction

    function automatic void fill(input int n, input int seed);
        for (int i = 0; i < n; i++) pix[i] = (i * 397 + seed * 131 + 37) & 'hFFF;
    endfunction

    // Sends one w x h frame from pix[] and checks outputs, checksum and flag (R6, R7, R8).
    task automatic run_frame(input int w, input int h, input bit bp, input bit chk_run);
        int n, in_i, out_i, cyc, d, csum_e;
        bit run_seen;
        n = w * h; in_i = 0; out_i = 0; cyc = 0; csum_e = 0; run_seen = 1'b0;
        wr(A_H, h);
        if (pend) begin act_g = shd_g; act_c = shd_c; pend = 1'b0; end
        for (int i = 0; i < n; i++) begin
            expv[i] = model(pix[i], (i / w) % 2, (i % w) % 2);
            csum_e = (csum_e + (expv[i] & 'hFF)) & 'hFF;
        end
        while (out_i < n && cyc < 5000) begin
            @(negedge clk);
            m_tready = bp ? ((cyc % 3) != 1 && (cyc % 7) != 4) : 1'b1;
            s_tvalid = (in_i < n) && (bp ? (cyc % 5) != 2 : 1'b1);
            s_tdata  = DW'(pix[in_i < n ? in_i : 0]);
            s_tuser  = (in_i == 0);
            s_tlast  = ((in_i % w) == w - 1);
            reg_addr = 8'(A_ST);
            #1;
            if (chk_run && in_i >= 1 && !run_seen) begin
                run_seen = 1'b1;
                chk(reg_rdata[0] == 1'b1, "R6", "flag mid-frame", longint'(reg_rdata[0]), 1);
            end
            if (m_tvalid && m_tready) begin
                chk(int'(m_tdata) == expv[out_i] && m_tuser == (out_i == 0)
                    && m_tlast == ((out_i % w) == w - 1),
                    bp ? "R8" : "R2", "pixel", longint'(m_tdata), longint'(expv[out_i]));
                out_i++;
            end
            if (s_tvalid && s_tready) in_i++;
            cyc++;
        end
        chk(out_i == n, "R8", "pixel count", out_i, n);
        @(negedge clk);
        s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
        rd(A_ST, d);
        chk((d & 1) == 0, "R6", "flag after frame", d & 1, 0);
        rd(A_CS, d);
        chk(d == csum_e, "R7", "checksum", d, csum_e);
    endtask

    task automatic t_reset();   // R1, R10
        int d;
        rd(A_ID, d); chk(d == 32'h6FA7017A, "R1", "id", d, 32'h6FA7017A);
        rd(A_PL, d); chk(d == 1, "R1", "plane count", d, 1);
        rd(A_ST, d); chk(d == 0, "R10", "status", d, 0);
        rd(A_CT, d); chk(d == 0, "R10", "control", d, 0);
        for (int k = 0; k < 4; k++) begin
            rd(A_G0 + 4 * k, d); chk(d == 'h800, "R10", "gain", d, 'h800);
        end
    endtask

    task automatic t_regs();    // R9
        int d;
        wr(A_W, 'h123); rd(A_W, d); chk(d == 'h123, "R9", "width", d, 'h123);
        wr(A_H, 'h0A5); rd(A_H, d); chk(d == 'h0A5, "R9", "height", d, 'h0A5);
        wr(A_G0 + 8, 32'hFFFF_FFFF); rd(A_G0 + 8, d);
        chk(d == 'h7FFFF, "R9", "gain field", d, 'h7FFFF);
        wr(A_G0 + 8, 'h800);
    endtask

    task automatic t_unity();   // R2
        fill(18, 1);
        run_frame(6, 3, 1'b0, 1'b1);
    endtask

    task automatic t_phase();   // R3
        wr(A_G0, 'h800); wr(A_G0 + 4, 'h1000); wr(A_G0 + 8, 'h400); wr(A_G0 + 12, 'h200);
        for (int p = 0; p < 4; p++) begin
            wr(A_CT, p << 1); wr(A_CM, 0);
            fill(16, p + 2);
            run_frame(4, 4, 1'b0, 1'b0);
        end
    endtask

    task automatic t_round();   // R2: half-up rounding and clamp
        wr(A_CT, 0);
        for (int k = 0; k < 4; k++) wr(A_G0 + 4 * k, 'h400);
        wr(A_CM, 0);
        fill(8, 3);
        pix[0] = 1; pix[1] = 3; pix[2] = 4095; pix[3] = 2;
        run_frame(4, 2, 1'b0, 1'b0);
        chk(expv[0] == 1 && expv[1] == 2, "R2", "rounding model", expv[1], 2);
        for (int k = 0; k < 4; k++) wr(A_G0 + 4 * k, 'h7FFFF);
        wr(A_CM, 0);
        fill(8, 4); pix[5] = 0;
        run_frame(4, 2, 1'b0, 1'b0);
    endtask

    task automatic t_shadow();  // R5
        int d;
        for (int k = 0; k < 4; k++) wr(A_G0 + 4 * k, 'h600 + k * 'h100);
        wr(A_CT, 2);
        rd(A_ST, d); chk((d & 2) == 0, "R5", "no pending", d & 2, 0);
        fill(12, 5);
        run_frame(4, 3, 1'b0, 1'b0);
        wr(A_CM, 'h55);
        rd(A_ST, d); chk((d & 2) == 2, "R5", "pending set", d & 2, 2);
        fill(12, 6);
        run_frame(4, 3, 1'b0, 1'b0);
        rd(A_ST, d); chk((d & 2) == 0, "R5", "pending cleared", d & 2, 0);
    endtask

    task automatic t_bypass();  // R4
        for (int k = 0; k < 4; k++) wr(A_G0 + 4 * k, 'h1800);
        wr(A_CT, 1); wr(A_CM, 0);
        fill(20, 7);
        run_frame(5, 4, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++)
            if (expv[i] != pix[i]) chk(1'b0, "R4", "bypass model", expv[i], pix[i]);
    endtask

    task automatic t_backpressure();  // R8
        wr(A_G0, 'h900); wr(A_G0 + 4, 'hA00); wr(A_G0 + 8, 'h700); wr(A_G0 + 12, 'hC00);
        wr(A_CT, 6); wr(A_CM, 0);
        fill(48, 8);
        run_frame(8, 6, 1'b1, 1'b1);
        fill(30, 9);
        run_frame(5, 6, 1'b1, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin shd_g[k] = 'h800; act_g[k] = 'h800; end
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unity();
        t_phase();
        t_round();
        t_shadow();
        t_bypass();
        t_backpressure();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule